// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion events from a bank of DMA channel engines and turns them into one interrupt line for the processor. Every channel has five kinds of event. A channel engine reports an event as a single-cycle pulse. The block latches each pulse into that channel's sticky status word. A per-channel enable word chooses which latched kinds count. A channel with at least one enabled, latched event raises its bit in a global pending vector. A global mask then chooses which pending channels may drive the interrupt output.

Software works through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address. Status bits and pending bits are cleared by writing ones. A read-only idle vector shows which channels are not busy, so a handler can confirm that an engine has stopped before it reprograms it. The usual service order is: read pending, clear the channel's status bits, then clear its pending bit.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every status word, enable word, the pending vector and the mask read as zero, and `irqOut` is low.
- R2: A pulse on `evtPulse[c*5+k]` sets bit k of channel c's status word at the next clock edge, and the bit then stays set. The event kinds are: bit 0 block done, bit 1 whole chain done, bit 2 frame done, bit 3 half frame, bit 4 last frame.
- R3: Channel c's status word is at word address 4+2c. Writing to it clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If an event pulse and a status clear reach the same bit in the same cycle, the bit ends up set.
- R5: Channel c's enable word is at word address 5+2c. It uses the same bit positions as the status word, stores data bits [4:0] and reads back with the upper bits zero.
- R6: Pending bit c (pending vector at address 0) is set at the clock edge after (status AND enable) of channel c becomes nonzero. A write-one clear cannot remove it while that AND is still nonzero.
- R7: Pending bit c stays set after channel c's status is cleared. It drops only when a 1 is written to bit c at address 0 and the channel's enabled status is zero in that cycle.
- R8: The mask at address 1 holds one bit per channel. `irqOut` is a register equal to the OR of (pending AND mask) from the cycle before, so it changes one cycle after a pending or mask change.
- R9: Address 2 is read-only: bit i reads 1 when `chanBusy[i]` is 0, with no clock delay.
- R10: `regRdata` follows `regAddr` combinationally. Address 3 and every address from 4+2·NUM_CH upward read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | NUM_CH*5 | Event pulses; five bits per channel, channel c at [c*5 +: 5] |
| chanBusy | input | NUM_CH | Per-channel busy level from the engines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the one where an event pulse and a software clear arrive on the same status bit in the same cycle. Close to it is a pending bit that software tries to clear while its channel still holds enabled events. Both need the register write and the channel pulse aligned to the same edge. The directed phase builds each one on purpose. A long phase then drives sparse random pulses alongside random writes to every address, and a behavioural model is compared on each clock, so the collisions also occur across channels and while the mask is changing.

// File: rtl/dma_irq_agg_pkg.sv
`timescale 1ns/1ps
package dma_irq_agg_pkg;
  // Number of event kinds per channel; bit positions are fixed by function.
  localparam int EVT_KINDS = 5;
  // Width of the channel index carried in the strobe struct (up to 64 channels).
  localparam int CH_IDX_W = 6;
  // Word address map.
  localparam int ADDR_PEND = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_IDLE = 2;
  localparam int CH_BASE   = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND,
    RD_MASK,
    RD_IDLE,
    RD_STAT,
    RD_ENA
  } rdSel_e;

  typedef struct packed {
    logic                wrPend;
    logic                wrMask;
    logic                wrStat;
    logic                wrEna;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] chIdx;
  } regStrobe_t;
endpackage

// File: rtl/dma_irq_agg_ctrl.sv
`timescale 1ns/1ps
module dma_irq_agg_ctrl
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam int CH_END = CH_BASE + 2 * NUM_CH;

  logic [ADDR_W-1:0] chOff;
  logic              inChan;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    chOff      = regAddr - ADDR_W'(CH_BASE);
    inChan     = (int'(regAddr) >= CH_BASE) && (int'(regAddr) < CH_END);
    strb.chIdx = CH_IDX_W'(chOff[ADDR_W-1:1]);
    if (regAddr == ADDR_W'(ADDR_PEND)) begin
      strb.rdSel  = RD_PEND;
      strb.wrPend = regWrEn;
    end else if (regAddr == ADDR_W'(ADDR_MASK)) begin
      strb.rdSel  = RD_MASK;
      strb.wrMask = regWrEn;
    end else if (regAddr == ADDR_W'(ADDR_IDLE)) begin
      strb.rdSel = RD_IDLE;
    end else if (inChan) begin
      if (chOff[0]) begin
        strb.rdSel = RD_ENA;
        strb.wrEna = regWrEn;
      end else begin
        strb.rdSel  = RD_STAT;
        strb.wrStat = regWrEn;
      end
    end
  end
endmodule

// File: rtl/dma_irq_agg_dp.sv
`timescale 1ns/1ps
module dma_irq_agg_dp
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStrobe_t                  strb,
  input  logic [DATA_W-1:0]           regWdata,
  input  logic [NUM_CH*EVT_KINDS-1:0] evtPulse,
  input  logic [NUM_CH-1:0]           chanBusy,
  output logic [DATA_W-1:0]           regRdata,
  output logic                        irqOut,
  output logic [NUM_CH*EVT_KINDS-1:0] statusFlat,
  output logic [NUM_CH*EVT_KINDS-1:0] enaFlat,
  output logic [NUM_CH-1:0]           pendVec,
  output logic [NUM_CH-1:0]           maskVec
);
  logic [NUM_CH-1:0] chanHit;
  logic [NUM_CH-1:0] pendR, maskR, pendClr, idleVec;
  logic              irqR;
  logic [EVT_KINDS-1:0] selStat, selEna;
  logic              unusedWd;

  assign unusedWd = ^regWdata;

  // Per-channel event capture and enable gating.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [EVT_KINDS-1:0] evtC, clrC, statR, enaR;
    logic                 selC;

    assign evtC = evtPulse[c*EVT_KINDS +: EVT_KINDS];
    assign selC = (int'(strb.chIdx) == c);
    assign clrC = (strb.wrStat && selC) ? regWdata[EVT_KINDS-1:0] : '0;

    // Event set has priority over the write-one clear.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statR <= '0;
      else       statR <= (statR & ~clrC) | evtC;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   enaR <= '0;
      else if (strb.wrEna && selC) enaR <= regWdata[EVT_KINDS-1:0];
    end

    assign chanHit[c] = |(statR & enaR);
    assign statusFlat[c*EVT_KINDS +: EVT_KINDS] = statR;
    assign enaFlat[c*EVT_KINDS +: EVT_KINDS]    = enaR;
  end

  // Global pending: level-set from the channel hit, write-one clear.
  assign pendClr = strb.wrPend ? regWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendR <= '0;
      maskR <= '0;
      irqR  <= 1'b0;
    end else begin
      pendR <= chanHit | (pendR & ~pendClr);
      if (strb.wrMask) maskR <= regWdata[NUM_CH-1:0];
      irqR  <= |(pendR & maskR);
    end
  end

  // Read path.
  assign idleVec = ~chanBusy;

  always_comb begin
    selStat = '0;
    selEna  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(strb.chIdx) == c) begin
        selStat = statusFlat[c*EVT_KINDS +: EVT_KINDS];
        selEna  = enaFlat[c*EVT_KINDS +: EVT_KINDS];
      end
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_PEND: regRdata = DATA_W'(pendR);
      RD_MASK: regRdata = DATA_W'(maskR);
      RD_IDLE: regRdata = DATA_W'(idleVec);
      RD_STAT: regRdata = DATA_W'(selStat);
      RD_ENA:  regRdata = DATA_W'(selEna);
      default: regRdata = '0;
    endcase
  end

  assign irqOut  = irqR;
  assign pendVec = pendR;
  assign maskVec = maskR;
endmodule

// File: rtl/dma_irq_agg.sv
`timescale 1ns/1ps
module dma_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH*EVT_KINDS-1:0] evtPulse,
  input  logic [NUM_CH-1:0]           chanBusy,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  output logic                        irqOut
);
  regStrobe_t                  strb;
  logic [NUM_CH*EVT_KINDS-1:0] statusFlat;
  logic [NUM_CH*EVT_KINDS-1:0] enaFlat;
  logic [NUM_CH-1:0]           pendVec;
  logic [NUM_CH-1:0]           maskVec;

  dma_irq_agg_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  dma_irq_agg_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWdata   (regWdata),
    .evtPulse   (evtPulse),
    .chanBusy   (chanBusy),
    .regRdata   (regRdata),
    .irqOut     (irqOut),
    .statusFlat (statusFlat),
    .enaFlat    (enaFlat),
    .pendVec    (pendVec),
    .maskVec    (maskVec)
  );
endmodule

// File: rtl/dma_irq_agg_chk.sv
`timescale 1ns/1ps
module dma_irq_agg_chk
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_CH*EVT_KINDS-1:0] evtPulse,
  input logic                        regWrEn,
  input logic [ADDR_W-1:0]           regAddr,
  input logic [EVT_KINDS-1:0]        wdLow,
  input logic [NUM_CH*EVT_KINDS-1:0] statusFlat,
  input logic [NUM_CH*EVT_KINDS-1:0] enaFlat,
  input logic [NUM_CH-1:0]           pendVec,
  input logic [NUM_CH-1:0]           maskVec,
  input logic                        irqOut
);
  // R2 R4
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusFlat & $past(evtPulse)) == $past(evtPulse)));

  // R8
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |=> !irqOut);

  // R8
  masked_pend_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendVec & maskVec)) |=> irqOut);

  // R10
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(3)) |=> ($stable(maskVec) && $stable(enaFlat)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'(CH_BASE + 2*c) &&
       evtPulse[c*EVT_KINDS +: EVT_KINDS] == '0)
      |=> ((statusFlat[c*EVT_KINDS +: EVT_KINDS] & $past(wdLow)) == '0));

    // R6
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
      (|(statusFlat[c*EVT_KINDS +: EVT_KINDS] & enaFlat[c*EVT_KINDS +: EVT_KINDS]))
      |=> pendVec[c]);

    // R7
    pend_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendVec[c]) |->
      $past(|(statusFlat[c*EVT_KINDS +: EVT_KINDS] & enaFlat[c*EVT_KINDS +: EVT_KINDS])));
  end
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtPulse   (evtPulse),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .wdLow      (regWdata[dma_irq_agg_pkg::EVT_KINDS-1:0]),
  .statusFlat (statusFlat),
  .enaFlat    (enaFlat),
  .pendVec    (pendVec),
  .maskVec    (maskVec),
  .irqOut     (irqOut)
);

// File: tb/dma_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_irq_agg_bench;
  localparam int NCH = 4;
  localparam int NE  = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH*NE-1:0] evtPulse = '0;
  logic [NCH-1:0]  chanBusy = 4'b0101;
  logic            regWrEn = 1'b0;
  logic [7:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .chanBusy(chanBusy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  // Behavioural reference model.
  logic [NE-1:0]  mStat [NCH];
  logic [NE-1:0]  mEna  [NCH];
  logic [NCH-1:0] mPend, mMask, hit, nPend;
  logic           mIrq, nIrq;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin mStat[c] = '0; mEna[c] = '0; end
      mPend = '0; mMask = '0; mIrq = 1'b0;
    end else begin
      nIrq = |(mPend & mMask);
      for (int c = 0; c < NCH; c++) hit[c] = |(mStat[c] & mEna[c]);
      nPend = hit | (mPend & ~((regWrEn && regAddr == 8'd0) ? regWdata[NCH-1:0] : '0));
      if (regWrEn && regAddr == 8'd1) mMask = regWdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        mStat[c] = (mStat[c] & ~((regWrEn && regAddr == 8'(4 + 2*c)) ? regWdata[NE-1:0] : '0))
                   | evtPulse[c*NE +: NE];
        if (regWrEn && regAddr == 8'(5 + 2*c)) mEna[c] = regWdata[NE-1:0];
      end
      mPend = nPend;
      mIrq  = nIrq;
    end
  end

  function automatic logic [31:0] mRead(input logic [7:0] a);
    int c;
    if (a == 8'd0) return {28'b0, mPend};
    if (a == 8'd1) return {28'b0, mMask};
    if (a == 8'd2) return {28'b0, ~chanBusy};
    if (a >= 8'd4 && a < 8'(4 + 2*NCH)) begin
      c = (int'(a) - 4) / 2;
      return a[0] ? {27'b0, mEna[c]} : {27'b0, mStat[c]};
    end
    return 32'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model (sampled mid-cycle).
  always @(negedge clk) begin
    if (monOn && rstN) begin
      chk("R8", {31'b0, irqOut}, {31'b0, mIrq});
      chk("R10", regRdata, mRead(regAddr));
    end
  end

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH*NE-1:0] ev);
    @(posedge clk); #2;
    regWrEn = we; regAddr = a; regWdata = d; evtPulse = ev;
  endtask

  task automatic idle();
    step(1'b0, regAddr, 32'b0, '0);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    step(1'b0, a, 32'b0, '0);
    @(negedge clk);
    chk(req, regRdata, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, irqOut}, 32'b0);
    for (int a = 0; a < 12; a++)
      if (a != 2) rdChk("R1", 8'(a), 32'b0);
    rdChk("R9", 8'd2, 32'h0000000A);
    monOn = 1'b1;

    // R5: enable words store five bits
    step(1'b1, 8'd7, 32'h15, '0);
    rdChk("R5", 8'd7, 32'h15);
    step(1'b1, 8'd9, 32'hFFFFFFFF, '0);
    rdChk("R5", 8'd9, 32'h1F);

    // R2: half-frame event on channel 0 is captured and sticky
    step(1'b0, 8'd0, 32'b0, 20'h00008);
    rdChk("R2", 8'd4, 32'h08);
    idle(); idle(); idle();
    rdChk("R2", 8'd4, 32'h08);
    rdChk("R6", 8'd0, 32'h0);

    // R3: write-one clear touches only written bits
    step(1'b0, 8'd0, 32'b0, 20'h00002);
    step(1'b1, 8'd4, 32'h02, '0);
    rdChk("R3", 8'd4, 32'h08);

    // R4: event beats a simultaneous clear
    step(1'b1, 8'd4, 32'h02, 20'h00002);
    rdChk("R4", 8'd4, 32'h0A);

    // R6: enable bit 3 of channel 0 -> pending bit 0
    step(1'b1, 8'd5, 32'h08, '0);
    idle();
    rdChk("R6", 8'd0, 32'h1);
    step(1'b1, 8'd0, 32'h1, '0);
    rdChk("R6", 8'd0, 32'h1);

    // R8: mask gates, output is one cycle behind
    @(negedge clk);
    chk("R8", {31'b0, irqOut}, 32'b0);
    step(1'b1, 8'd1, 32'h1, '0);
    rdChk("R8", 8'd1, 32'h1);
    chk("R8", {31'b0, irqOut}, 32'b0);
    @(negedge clk);
    chk("R8", {31'b0, irqOut}, 32'b1);

    // R7: pending sticky after status clear, then write-one clear
    step(1'b1, 8'd4, 32'h1F, '0);
    idle();
    rdChk("R7", 8'd4, 32'h0);
    rdChk("R7", 8'd0, 32'h1);
    step(1'b1, 8'd0, 32'h1, '0);
    rdChk("R7", 8'd0, 32'h0);
    idle();
    @(negedge clk);
    chk("R8", {31'b0, irqOut}, 32'b0);

    // R10: reserved and out-of-range addresses
    step(1'b1, 8'd3, 32'hFFFFFFFF, '0);
    step(1'b1, 8'd12, 32'hFFFFFFFF, '0);
    step(1'b1, 8'd200, 32'hFFFFFFFF, '0);
    rdChk("R10", 8'd3, 32'h0);
    rdChk("R10", 8'd12, 32'h0);
    rdChk("R10", 8'd1, 32'h1);
    rdChk("R10", 8'd5, 32'h08);
    rdChk("R10", 8'd7, 32'h15);

    // R9: idle follows busy without delay
    chanBusy = 4'b1110;
    rdChk("R9", 8'd2, 32'h1);

    // Mixed traffic across channels, compared each clock by the model
    for (int i = 0; i < 600; i++) begin
      logic [NCH*NE-1:0] ev;
      logic we;
      for (int b = 0; b < NCH*NE; b++) ev[b] = (($urandom % 10) == 0);
      we = (($urandom % 3) == 0);
      step(we, 8'($urandom % 14), $urandom, ev);
      if ((i % 40) == 0) chanBusy = 4'($urandom);
    end
    idle(); idle();
    @(negedge clk);
    finishRun();
  end
endmodule